// File: doc/BRIEF.md
# Four-phase differential sign-pattern dibit detector

This block recovers two-bit symbols from a carrier that moves in steps of 90 degrees, with the data carried in the phase change between signalling intervals. Each interval delivers four signed samples at fixed instants. The detector keeps only the sign of each sample. It classifies the four signs as one of four absolute starting phases. It then subtracts the phase held from the last good interval and turns the difference into a dibit.

An interval opens with a start strobe. The samples follow on a sample strobe, and the sample that arrives in the same cycle as the start strobe counts as the first one. One cycle after the fourth accepted sample the block pulses either a dibit with its valid flag or an error flag. The error flag means the sign pattern was not one of the four legal shapes. The first good interval after reset produces no dibit. It only sets the phase reference for the intervals that follow.

Top module: `dpsk_dibit_det`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, dibit_o, dibit_vld_o and err_o are 0. No phase reference is held.
- R2: A sample counts as negative only when its two's-complement value is below zero, so zero counts as positive. Magnitude has no effect on the decision.
- R3: Write the signs as sample1 sample2 sample3 sample4, with sample1 the first accepted. The pattern ++++ is phase index 0 (0°), ++-- is 1 (+90°), ---- is 2 (+180°) and --++ is 3 (+270°).
- R4: With a reference present, d = (current index - reference index) mod 4. dibit_o is 00 for d=0, 01 for d=1, 11 for d=2 and 10 for d=3. The current index then becomes the reference.
- R5: A legal interval decided while no reference is held sets the reference and emits neither dibit_vld_o nor err_o.
- R6: Any other sign pattern raises err_o. No dibit is emitted, and the reference and whether one exists stay unchanged.
- R7: dibit_vld_o or err_o is high for exactly one cycle, the cycle after the edge that accepts the fourth sample of an interval. At no other time is either high, and never both at once.
- R8: start_i opens a new interval. A sample strobe in the same cycle is taken as sample1. Sample strobes before the first start_i after reset, or after the fourth sample of an interval, are ignored.
- R9: A start_i that arrives before an interval has four samples throws away the samples gathered so far. Counting begins again from sample1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a signalling interval |
| smp_vld_i | input | 1 | Sample strobe |
| smp_i | input | SMP_W | Two's-complement sample |
| dibit_o | output | 2 | Decided dibit, first bit in bit 1 |
| dibit_vld_o | output | 1 | One-cycle dibit strobe |
| err_o | output | 1 | One-cycle illegal-pattern flag |

## Verification
The one-cycle pulse properties take for granted that consecutive fourth-sample strobes are at least two cycles apart. Since an interval needs four accepted samples, this holds for any input sequence. The stimulus therefore needs no special spacing. It drives intervals back to back, with and without a lone start cycle. It also sends stray strobes before the first start, extra strobes after the fourth sample, and restarts in the middle of an interval. Sample magnitudes cycle through zero, small values and full-scale values of both signs.

// File: rtl/dpsk_pkg.sv
`timescale 1ns/1ps
package dpsk_pkg;
  localparam int unsigned N_SMP = 4;
  localparam int unsigned PH_W  = 2;

  typedef logic [PH_W-1:0] phase_t;
  typedef logic [1:0]      dibit_t;

  // phase step in quarter turns -> reflected binary dibit
  function automatic dibit_t step_to_dibit(phase_t d);
    dibit_t r;
    unique case (d)
      2'd0: r = 2'b00;
      2'd1: r = 2'b01;
      2'd2: r = 2'b11;
      default: r = 2'b10;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/dpsk_sign_acc.sv
`timescale 1ns/1ps
module dpsk_sign_acc #(
  parameter int unsigned SMP_W  = 8,
  parameter int unsigned N      = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             smp_vld_i,
  input  logic [SMP_W-1:0] smp_i,
  output logic             done_o,
  output logic [N-1:0]     pat_o
);
  localparam int unsigned CNT_W = $clog2(N + 1);
  localparam logic [CNT_W-1:0] IDLE = CNT_W'(N);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(N - 1);

  logic [CNT_W-1:0] cnt_q, eff_cnt;
  logic             take, neg;

  assign neg     = $signed(smp_i) < 0;
  assign eff_cnt = start_i ? '0 : cnt_q;
  assign take    = smp_vld_i && (eff_cnt < IDLE);
  assign done_o  = take && (eff_cnt == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= IDLE;
    else if (take)   cnt_q <= eff_cnt + 1'b1;
    else             cnt_q <= eff_cnt;
  end

  // stored signs for all but the last slot; last slot is the live sample
  for (genvar i = 0; i < N - 1; i++) begin : g_slot
    logic sgn_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  sgn_q <= 1'b0;
      else if (take && eff_cnt == CNT_W'(i))        sgn_q <= neg;
    end
    assign pat_o[i] = sgn_q;
  end
  assign pat_o[N-1] = neg;
endmodule

// File: rtl/dpsk_phase_lut.sv
`timescale 1ns/1ps
module dpsk_phase_lut
  import dpsk_pkg::*;
(
  input  logic [N_SMP-1:0] pat_i,
  output phase_t           ph_o,
  output logic             ok_o
);
  logic head_neg, tail_neg;

  // legal shapes have equal signs within each half
  assign ok_o     = (pat_i[0] == pat_i[1]) && (pat_i[2] == pat_i[3]);
  assign head_neg = pat_i[0];
  assign tail_neg = pat_i[2];
  assign ph_o     = {head_neg, head_neg ^ tail_neg};
endmodule

// File: rtl/dpsk_diff_map.sv
`timescale 1ns/1ps
module dpsk_diff_map
  import dpsk_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   done_i,
  input  logic   ok_i,
  input  phase_t ph_i,
  output dibit_t dibit_o,
  output logic   dibit_vld_o,
  output logic   err_o,
  output logic   has_ref_o,
  output phase_t ref_ph_o
);
  phase_t ref_q, step;
  logic   has_ref_q;

  assign step = ph_i - ref_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q       <= '0;
      has_ref_q   <= 1'b0;
      dibit_o     <= '0;
      dibit_vld_o <= 1'b0;
      err_o       <= 1'b0;
    end else begin
      dibit_vld_o <= 1'b0;
      err_o       <= 1'b0;
      if (done_i) begin
        if (!ok_i) begin
          err_o <= 1'b1;
        end else begin
          ref_q     <= ph_i;
          has_ref_q <= 1'b1;
          if (has_ref_q) begin
            dibit_o     <= step_to_dibit(step);
            dibit_vld_o <= 1'b1;
          end
        end
      end
    end
  end

  assign has_ref_o = has_ref_q;
  assign ref_ph_o  = ref_q;
endmodule

// File: rtl/dpsk_dibit_det.sv
`timescale 1ns/1ps
module dpsk_dibit_det
  import dpsk_pkg::*;
#(
  parameter int unsigned SMP_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             smp_vld_i,
  input  logic [SMP_W-1:0] smp_i,
  output logic [1:0]       dibit_o,
  output logic             dibit_vld_o,
  output logic             err_o
);
  logic [N_SMP-1:0] sgn_pat;
  logic             sgn_done, ph_ok, has_ref;
  phase_t           cur_ph, ref_ph;

  dpsk_sign_acc #(.SMP_W(SMP_W), .N(N_SMP)) u_acc (
    .clk_i, .rst_ni, .start_i, .smp_vld_i, .smp_i,
    .done_o(sgn_done), .pat_o(sgn_pat)
  );

  dpsk_phase_lut u_lut (
    .pat_i(sgn_pat), .ph_o(cur_ph), .ok_o(ph_ok)
  );

  dpsk_diff_map u_map (
    .clk_i, .rst_ni, .done_i(sgn_done), .ok_i(ph_ok), .ph_i(cur_ph),
    .dibit_o, .dibit_vld_o, .err_o,
    .has_ref_o(has_ref), .ref_ph_o(ref_ph)
  );
endmodule

// File: rtl/dpsk_dibit_det_chk.sv
`timescale 1ns/1ps
module dpsk_dibit_det_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       smp_vld_i,
  input logic       dibit_vld_o,
  input logic       err_o,
  input logic       sgn_done,
  input logic       ph_ok,
  input logic       has_ref,
  input logic [1:0] ref_ph
);
  assert_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dibit_vld_o && err_o));

  assert_vld_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dibit_vld_o |=> !dibit_vld_o);

  assert_err_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);

  assert_after_smp_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dibit_vld_o || err_o) |-> $past(smp_vld_i && sgn_done));

  assert_legal_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dibit_vld_o |-> $past(ph_ok));

  assert_first_ref_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dibit_vld_o |-> $past(has_ref));

  assert_ref_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ($stable(ref_ph) && $stable(has_ref)));
endmodule

bind dpsk_dibit_det dpsk_dibit_det_chk u_chk (
  .clk_i, .rst_ni, .smp_vld_i, .dibit_vld_o, .err_o,
  .sgn_done, .ph_ok, .has_ref, .ref_ph
);

// File: tb/test_dpsk_dibit_det.sv
`timescale 1ns/1ps
module test_dpsk_dibit_det;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic       smp_vld_i = 1'b0;
  logic [7:0] smp_i = '0;
  logic [1:0] dibit_o;
  logic       dibit_vld_o, err_o;

  int vectors = 0;
  int fails = 0;
  int vsel = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dpsk_dibit_det i_dpsk_dibit_det (
    .clk_i(clk), .rst_ni, .start_i, .smp_vld_i, .smp_i,
    .dibit_o, .dibit_vld_o, .err_o
  );

  // behavioural reference model
  int  m_cnt;
  bit  m_q[$];
  bit  m_have_ref;
  int  m_ref;
  bit  e_vld, e_err;
  int  e_dibit;
  int  gmap[4] = '{0, 1, 3, 2};

  function automatic int decode(bit s1, bit s2, bit s3, bit s4);
    if (!s1 && !s2 && !s3 && !s4) return 0;
    if (!s1 && !s2 &&  s3 &&  s4) return 1;
    if ( s1 &&  s2 &&  s3 &&  s4) return 2;
    if ( s1 &&  s2 && !s3 && !s4) return 3;
    return -1;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = -1; m_q.delete(); m_have_ref = 0; m_ref = 0;
      e_vld = 0; e_err = 0; e_dibit = 0;
    end else begin
      int ph;
      e_vld = 0; e_err = 0;
      if (start_i) begin m_cnt = 0; m_q.delete(); end
      if (smp_vld_i && m_cnt >= 0 && m_cnt < 4) begin
        m_q.push_back($signed(smp_i) < 0);
        m_cnt++;
        if (m_cnt == 4) begin
          ph = decode(m_q[0], m_q[1], m_q[2], m_q[3]);
          if (ph < 0) e_err = 1;
          else begin
            if (m_have_ref) begin
              e_vld = 1;
              e_dibit = gmap[(ph - m_ref + 4) % 4];
            end
            m_ref = ph; m_have_ref = 1;
          end
        end
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      vectors++;
      if (err_o !== e_err) begin
        fails++;
        $display("FAIL R6 err_o actual=%0b expected=%0b t=%0t", err_o, e_err, $time);
      end
      if (dibit_vld_o !== e_vld) begin
        fails++;
        $display("FAIL R7 dibit_vld_o actual=%0b expected=%0b t=%0t", dibit_vld_o, e_vld, $time);
      end
      if (e_vld && dibit_o !== 2'(e_dibit)) begin
        fails++;
        $display("FAIL R4 dibit_o actual=%0b expected=%0b t=%0t", dibit_o, 2'(e_dibit), $time);
      end
      if (!rst_ni && (dibit_o !== 2'b00)) begin
        fails++;
        $display("FAIL R1 dibit_o in reset actual=%0b expected=00", dibit_o);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  function automatic logic [7:0] pick(bit neg);
    logic [7:0] pos_v[4] = '{8'h00, 8'h01, 8'h40, 8'h7F};
    logic [7:0] neg_v[4] = '{8'h81, 8'hFF, 8'hC0, 8'hF0};
    vsel++;
    return neg ? neg_v[vsel % 4] : pos_v[(vsel / 3) % 4];
  endfunction

  // bit 0 of neg is sample1
  function automatic logic [3:0] shape(int ph);
    case (ph)
      0: return 4'b0000;
      1: return 4'b1100;
      2: return 4'b1111;
      default: return 4'b0011;
    endcase
  endfunction

  task automatic send(logic [3:0] neg, bit lead, int extra, int gap);
    if (lead) begin start_i = 1; smp_vld_i = 0; tick(); end
    start_i = !lead; smp_vld_i = 1; smp_i = pick(neg[0]); tick();
    start_i = 0;
    for (int k = 1; k < 4; k++) begin smp_i = pick(neg[k]); tick(); end
    for (int k = 0; k < extra; k++) begin smp_i = pick(k[0]); tick(); end
    smp_vld_i = 0;
    for (int k = 0; k < gap; k++) tick();
  endtask

  initial begin
    // R1: reset state
    repeat (4) tick();
    rst_ni = 1; tick(); tick();
    // R8: strobes before any start are ignored
    smp_vld_i = 1;
    for (int k = 0; k < 6; k++) begin smp_i = pick(k[1]); tick(); end
    smp_vld_i = 0; tick();
    // R6 with no reference yet, then R5 first reference
    send(4'b0101, 0, 0, 2);
    send(shape(2), 1, 0, 2);
    // R3 R4: every transition, mixed leads, extras (R8), back to back
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++) begin
        send(shape(a), b[0], b, a[0] ? 0 : 1);
        send(shape(b), a[0], 0, 0);
      end
    // R6: illegal shapes leave the reference alone
    send(shape(1), 0, 0, 1);
    send(4'b1000, 0, 0, 1);
    send(4'b0110, 1, 0, 0);
    send(shape(3), 0, 0, 1);
    // R9: restart mid interval
    start_i = 1; smp_vld_i = 1; smp_i = 8'h80; tick();
    start_i = 0; smp_i = 8'hFF; tick();
    smp_vld_i = 0; tick();
    send(shape(0), 0, 0, 1);
    start_i = 1; smp_vld_i = 1; smp_i = 8'h01; tick();
    start_i = 0; smp_i = 8'hC0; tick(); smp_i = 8'hC0; tick();
    send(shape(1), 1, 0, 1);
    // R2: zero and tiny magnitudes
    smp_vld_i = 1; start_i = 1;
    smp_i = 8'h00; tick(); start_i = 0; tick(); smp_i = 8'hFF; tick(); tick();
    smp_vld_i = 0; tick();
    smp_vld_i = 1; start_i = 1;
    smp_i = 8'h00; tick(); start_i = 0; tick(); tick(); tick();
    smp_vld_i = 0;
    repeat (3) tick();
    // R1: reset in the middle, then reference rebuilt (R5)
    start_i = 1; smp_vld_i = 1; smp_i = 8'h10; tick();
    start_i = 0; rst_ni = 0; tick(); tick();
    smp_vld_i = 0; rst_ni = 1; tick();
    send(shape(3), 0, 0, 1);
    send(shape(0), 0, 0, 3);
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL R7 watchdog actual=running expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule